// File: doc/BRIEF.md
# Parallel Compare Predicate Writer

This block holds a file of one-bit predicate registers and applies the outcome of up to `NPORT` compares to it each clock. Each compare port supplies a boolean result, a not-a-thing flag for each of its two source operands, a qualifying predicate index, two target indices and an update kind. The kind decides whether both targets are always written, written only on a true or false outcome, or written with complementary values.

Writes take effect at the next rising clock edge. The qualifying predicate is read from the register state before that edge. Entry 0 is a constant true. Several ports may update the same pair of targets in one cycle. When they all use the same parallel kind, their effects combine as a wired AND or a wired OR, so a chain of conditions can collapse into a single predicate pair in one cycle.

Top module: `pred_cmp_writer`

## Requirements
- R1: After reset, `pred_o` reads 64'h1: entry 0 is 1 and every other entry is 0.
- R2: Normal kind (code 0) with a true qualifier writes the result to target 1 and its complement to target 2.
- R3: Normal or unconditional kind with either NaT flag set writes 0 to both targets, provided the kind writes at all.
- R4: Unconditional kind (code 1) always writes both targets. With a true qualifier and no NaT it writes (result, !result). With a false qualifier it writes (0, 0).
- R5: Any kind other than unconditional leaves the file unchanged when its qualifier is false. A port with valid low, or with kind code 6 or 7, also leaves the file unchanged.
- R6: And kind (code 2) clears both targets when the effective outcome is false, and otherwise leaves them unchanged.
- R7: Or kind (code 3) sets both targets when the effective outcome is true, and otherwise leaves them unchanged.
- R8: And-orcm kind (code 4) writes (0, 1) on a false outcome. Or-andcm kind (code 5) writes (1, 0) on a true outcome. Otherwise both kinds leave the targets unchanged.
- R9: Several ports of the same parallel kind that hit the same targets in one cycle combine their effects without conflict, as a wired AND or a wired OR.
- R10: Entry 0 always reads 1, and any write to it is dropped. The other target of that compare is still written.
- R11: For the four parallel kinds (codes 2 to 5), a set NaT flag makes the effective outcome false.
- R12: When ports write opposite values to one entry in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_vld_i | input | NPORT | Compare valid, one bit per port |
| cmp_kind_i | input | NPORT x 3 | Update kind per port |
| cmp_qp_i | input | NPORT x IDXW | Qualifying predicate index |
| cmp_t1_i | input | NPORT x IDXW | First target index |
| cmp_t2_i | input | NPORT x IDXW | Second target index |
| cmp_res_i | input | NPORT | Compare outcome |
| cmp_nat_a_i | input | NPORT | NaT flag of source A |
| cmp_nat_b_i | input | NPORT | NaT flag of source B |
| pred_o | output | NPRED | Current predicate file, entry 0 forced to 1 |

## Verification
The assertions assume that the valid, kind and index inputs are known whenever reset is released. They also assume that ports sharing a target in one cycle are either of the same parallel kind or are meant to resolve by the clear-wins rule. The stimulus drives every port to zero between scenarios and changes inputs only on the falling edge. It raises valid only on ports whose kinds and targets meet those assumptions, apart from the single case that deliberately tests the clear-wins resolution.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
  typedef enum logic [2:0] {
    K_NORM     = 3'd0,
    K_UNC      = 3'd1,
    K_AND      = 3'd2,
    K_OR       = 3'd3,
    K_AND_ORCM = 3'd4,
    K_OR_ANDCM = 3'd5
  } cmp_kind_e;
endpackage

// File: rtl/pcmp_decode.sv
module pcmp_decode
  import pcmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vld_i,
  input  logic [2:0] kind_i,
  input  logic       qp_i,
  input  logic       res_i,
  input  logic       nat_i,
  output logic       wr1_o,
  output logic       val1_o,
  output logic       wr2_o,
  output logic       val2_o
);
  logic eff;
  assign eff = res_i & ~nat_i;

  always_comb begin
    wr1_o = 1'b0; val1_o = 1'b0; wr2_o = 1'b0; val2_o = 1'b0;
    if (vld_i) begin
      case (kind_i)
        K_NORM: if (qp_i) begin
          wr1_o = 1'b1; wr2_o = 1'b1;
          val1_o = eff; val2_o = ~res_i & ~nat_i;
        end
        K_UNC: begin
          wr1_o = 1'b1; wr2_o = 1'b1;
          val1_o = qp_i & eff; val2_o = qp_i & ~res_i & ~nat_i;
        end
        K_AND: if (qp_i && !eff) begin
          wr1_o = 1'b1; wr2_o = 1'b1;
        end
        K_OR: if (qp_i && eff) begin
          wr1_o = 1'b1; wr2_o = 1'b1; val1_o = 1'b1; val2_o = 1'b1;
        end
        K_AND_ORCM: if (qp_i && !eff) begin
          wr1_o = 1'b1; wr2_o = 1'b1; val2_o = 1'b1;
        end
        K_OR_ANDCM: if (qp_i && eff) begin
          wr1_o = 1'b1; wr2_o = 1'b1; val1_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_UNC_NAT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && kind_i == K_UNC && nat_i) |-> (wr1_o && wr2_o && !val1_o && !val2_o)); // R3
  AST_UNQUAL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && kind_i != K_UNC && !qp_i) |-> (!wr1_o && !wr2_o)); // R5
  AST_AND_NEVER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_AND && wr1_o) |-> (!val1_o && !val2_o)); // R6
  AST_OR_NEVER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_OR && wr1_o) |-> (val1_o && val2_o)); // R7
endmodule

// File: rtl/pcmp_merge.sv
module pcmp_merge #(
  parameter int NPRED = 64,
  parameter int NPORT = 3,
  localparam int IDXW = $clog2(NPRED)
) (
  input  logic [NPORT-1:0]           wr1_i,
  input  logic [NPORT-1:0]           val1_i,
  input  logic [NPORT-1:0][IDXW-1:0] t1_i,
  input  logic [NPORT-1:0]           wr2_i,
  input  logic [NPORT-1:0]           val2_i,
  input  logic [NPORT-1:0][IDXW-1:0] t2_i,
  output logic [NPRED-1:0]           wr_mask_o,
  output logic [NPRED-1:0]           clr_mask_o
);
  // wired combine: any writer asserting 0 dominates
  always_comb begin
    wr_mask_o  = '0;
    clr_mask_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (wr1_i[p]) begin
        wr_mask_o[t1_i[p]] = 1'b1;
        if (!val1_i[p]) clr_mask_o[t1_i[p]] = 1'b1;
      end
      if (wr2_i[p]) begin
        wr_mask_o[t2_i[p]] = 1'b1;
        if (!val2_i[p]) clr_mask_o[t2_i[p]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pred_cmp_writer.sv
module pred_cmp_writer #(
  parameter int NPRED = 64,
  parameter int NPORT = 3,
  localparam int IDXW = $clog2(NPRED)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPORT-1:0]           cmp_vld_i,
  input  logic [NPORT-1:0][2:0]      cmp_kind_i,
  input  logic [NPORT-1:0][IDXW-1:0] cmp_qp_i,
  input  logic [NPORT-1:0][IDXW-1:0] cmp_t1_i,
  input  logic [NPORT-1:0][IDXW-1:0] cmp_t2_i,
  input  logic [NPORT-1:0]           cmp_res_i,
  input  logic [NPORT-1:0]           cmp_nat_a_i,
  input  logic [NPORT-1:0]           cmp_nat_b_i,
  output logic [NPRED-1:0]           pred_o
);
  logic [NPRED-1:1] pred_q;
  logic [NPORT-1:0] wr1, val1, wr2, val2;
  logic [NPRED-1:0] wr_mask, clr_mask;

  assign pred_o = {pred_q, 1'b1};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pcmp_decode u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (cmp_vld_i[p]),
      .kind_i (cmp_kind_i[p]),
      .qp_i   (pred_o[cmp_qp_i[p]]),
      .res_i  (cmp_res_i[p]),
      .nat_i  (cmp_nat_a_i[p] | cmp_nat_b_i[p]),
      .wr1_o  (wr1[p]),
      .val1_o (val1[p]),
      .wr2_o  (wr2[p]),
      .val2_o (val2[p])
    );
  end

  pcmp_merge #(.NPRED(NPRED), .NPORT(NPORT)) u_merge (
    .wr1_i      (wr1),
    .val1_i     (val1),
    .t1_i       (cmp_t1_i),
    .wr2_i      (wr2),
    .val2_i     (val2),
    .t2_i       (cmp_t2_i),
    .wr_mask_o  (wr_mask),
    .clr_mask_o (clr_mask)
  );

  for (genvar i = 1; i < NPRED; i++) begin : g_pred
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pred_q[i] <= 1'b0;
      else if (wr_mask[i]) pred_q[i] <= ~clr_mask[i];
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_vld_i == '0) |=> $stable(pred_o)); // R5
  AST_P0_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_vld_i != '0) |=> pred_o[0]); // R10
endmodule

// File: tb/pred_cmp_writer_tb_top.sv
module pred_cmp_writer_tb_top;
  localparam int NPRED = 64;
  localparam int NPORT = 3;
  localparam int IDXW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPORT-1:0]           vld, res, nat_a, nat_b;
  logic [NPORT-1:0][2:0]      kind;
  logic [NPORT-1:0][IDXW-1:0] qp, t1, t2;
  logic [NPRED-1:0]           pred;
  logic [NPRED-1:0]           exp_v;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pred_cmp_writer #(.NPRED(NPRED), .NPORT(NPORT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_vld_i(vld), .cmp_kind_i(kind),
    .cmp_qp_i(qp), .cmp_t1_i(t1), .cmp_t2_i(t2), .cmp_res_i(res),
    .cmp_nat_a_i(nat_a), .cmp_nat_b_i(nat_b), .pred_o(pred)
  );

  task automatic idle();
    vld = '0; kind = '0; qp = '0; t1 = '0; t2 = '0;
    res = '0; nat_a = '0; nat_b = '0;
  endtask

  task automatic drive(int p, int k, int q, int a, int b, bit r, bit na, bit nb);
    vld[p] = 1'b1; kind[p] = 3'(k); qp[p] = IDXW'(q);
    t1[p] = IDXW'(a); t2[p] = IDXW'(b); res[p] = r; nat_a[p] = na; nat_b[p] = nb;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic chk(string tag);
    n_chk++;
    if (pred !== exp_v) begin
      n_fail++;
      $display("FAIL %s: pred=%h expected=%h", tag, pred, exp_v);
    end
  endtask

  task automatic t_reset();
    exp_v = 64'h1; chk("R1 reset");
  endtask

  task automatic t_normal();
    drive(0, 0, 0, 5, 6, 1, 0, 0); step();
    exp_v[5] = 1; exp_v[6] = 0; chk("R2 normal true");
    drive(0, 0, 0, 5, 6, 0, 0, 0); step();
    exp_v[5] = 0; exp_v[6] = 1; chk("R2 normal false");
    drive(0, 0, 0, 5, 7, 1, 0, 0); step();
    exp_v[5] = 1; exp_v[7] = 0; chk("R2 setup");
    drive(0, 0, 0, 5, 6, 1, 0, 1); step();
    exp_v[5] = 0; exp_v[6] = 0; chk("R3 normal NaT");
  endtask

  task automatic t_unc();
    drive(0, 1, 0, 8, 9, 1, 0, 0); step();
    exp_v[8] = 1; exp_v[9] = 0; chk("R4 unc init");
    drive(0, 1, 9, 8, 13, 1, 0, 0); step();
    exp_v[8] = 0; exp_v[13] = 0; chk("R4 unc qp false");
    drive(0, 0, 0, 8, 9, 0, 0, 0); step();
    exp_v[8] = 0; exp_v[9] = 1; chk("R2 setup 8/9");
    drive(0, 1, 0, 8, 9, 1, 1, 0); step();
    exp_v[8] = 0; exp_v[9] = 0; chk("R3 unc NaT");
  endtask

  task automatic t_qual();
    drive(0, 0, 0, 14, 15, 1, 0, 0); step();
    exp_v[14] = 1; exp_v[15] = 0; chk("R2 setup 14/15");
    drive(0, 0, 9, 14, 15, 0, 0, 0);
    drive(1, 4, 9, 14, 15, 0, 0, 0);
    drive(2, 3, 9, 15, 15, 1, 0, 0); step();
    chk("R5 qp false no write");
    drive(0, 6, 0, 14, 15, 0, 0, 0);
    drive(1, 7, 0, 14, 15, 0, 0, 0); step();
    chk("R5 reserved kinds");
    kind[0] = 3'd0; t1[0] = 6'd14; t2[0] = 6'd15; step();
    chk("R5 valid low");
  endtask

  task automatic t_and_or();
    drive(0, 3, 0, 10, 11, 1, 0, 0); step();
    exp_v[10] = 1; exp_v[11] = 1; chk("R7 or sets");
    drive(0, 3, 0, 10, 11, 0, 0, 0); step();
    chk("R7 or false no change");
    drive(0, 2, 0, 10, 11, 1, 0, 0); step();
    chk("R6 and true no change");
    drive(0, 2, 0, 10, 11, 0, 0, 0); step();
    exp_v[10] = 0; exp_v[11] = 0; chk("R6 and clears");
    drive(0, 2, 0, 10, 11, 1, 0, 0); step();
    chk("R6 and true keeps cleared");
  endtask

  task automatic t_demorgan();
    drive(0, 1, 0, 16, 17, 1, 0, 0); step();
    exp_v[16] = 1; exp_v[17] = 0; chk("R4 pair init 16/17");
    drive(0, 4, 0, 16, 17, 1, 0, 0); step();
    chk("R8 and.orcm true no change");
    drive(0, 4, 0, 16, 17, 0, 0, 0); step();
    exp_v[16] = 0; exp_v[17] = 1; chk("R8 and.orcm false");
    drive(0, 5, 0, 16, 17, 0, 0, 0); step();
    chk("R8 or.andcm false no change");
    drive(0, 5, 0, 16, 17, 1, 0, 0); step();
    exp_v[16] = 1; exp_v[17] = 0; chk("R8 or.andcm true");
  endtask

  task automatic t_wired();
    drive(0, 1, 0, 20, 21, 1, 0, 0); step();
    exp_v[20] = 1; exp_v[21] = 0; chk("R4 pair init 20/21");
    for (int p = 0; p < NPORT; p++) drive(p, 4, 0, 20, 21, 1, 0, 0);
    step(); chk("R9 wired and all true");
    drive(0, 4, 0, 20, 21, 1, 0, 0);
    drive(1, 4, 0, 20, 21, 0, 0, 0);
    drive(2, 4, 0, 20, 21, 1, 0, 0); step();
    exp_v[20] = 0; exp_v[21] = 1; chk("R9 wired and one false");
    drive(0, 3, 0, 30, 31, 0, 0, 0);
    drive(1, 3, 0, 30, 31, 0, 0, 0);
    drive(2, 3, 0, 30, 31, 1, 0, 0); step();
    exp_v[30] = 1; exp_v[31] = 1; chk("R9 wired or one true");
  endtask

  task automatic t_p0();
    drive(0, 0, 0, 0, 12, 0, 0, 0); step();
    exp_v[12] = 1; chk("R10 write to p0 dropped");
    drive(0, 2, 0, 12, 0, 0, 0, 0); step();
    exp_v[12] = 0; chk("R10 p0 stays one");
  endtask

  task automatic t_par_nat();
    drive(0, 3, 0, 40, 41, 1, 0, 0); step();
    exp_v[40] = 1; exp_v[41] = 1; chk("R7 setup 40/41");
    drive(0, 3, 0, 40, 41, 1, 1, 0); step();
    chk("R11 or NaT no change");
    drive(0, 2, 0, 40, 41, 1, 0, 1); step();
    exp_v[40] = 0; exp_v[41] = 0; chk("R11 and NaT clears");
    drive(0, 4, 0, 40, 41, 1, 1, 1); step();
    exp_v[41] = 1; chk("R11 and.orcm NaT");
  endtask

  task automatic t_conflict();
    drive(0, 0, 0, 50, 51, 1, 0, 0);
    drive(1, 0, 0, 50, 52, 0, 0, 0); step();
    exp_v[50] = 0; exp_v[51] = 0; exp_v[52] = 1; chk("R12 clear wins");
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_unc();
    t_qual();
    t_and_or();
    t_demorgan();
    t_wired();
    t_p0();
    t_par_nat();
    t_conflict();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule